// File: doc/BRIEF.md
# Programmable Interval Counter Channel

A single 16-bit down-counting timer channel with six waveform modes, a gate input and a choice of binary or four-digit decimal (BCD) counting. The channel advances only on cycles where the `tick` enable is high, so one system clock can drive it from a slower counting rate. Software-facing logic outside the block writes an initial count, a mode and a number base, then pulses `load`. The block then produces the mode's output waveform on `out` and shows the live counter value on `count`.

No data flows through the block, so every pin is a plain control or status level and there is no valid/ready handshake. `load` is a one-cycle strobe that is always accepted. The configuration pins are sampled only in that cycle. `tick` and `gate` are levels sampled on every rising clock edge.

In the requirements, "elapsed ticks" d is the number of counting ticks since the last load or restart. N is the effective initial count.

Top module: `timer_channel`

## Requirements
- R1: A synchronous reset leaves the channel unarmed, with `out` low and `count` 0. Until the first `load`, `tick` and `gate` have no effect on either output.
- R2: `load` captures `init_count`, `mode` and `bcd` and sets d to 0. From the next cycle, `count` shows the initial value. `load` takes priority over a tick or gate edge in the same cycle. Mode values 6 and 7 behave exactly as modes 2 and 3.
- R3: An initial count of 0 is taken as N = 65536 in binary or 10000 in BCD, and `count` then displays 0000.
- R4: In modes 0, 1, 4 and 5, `count` equals (N − d) modulo the base. It steps down by one per tick and, after 0, wraps to 0xFFFF (binary) or 9999 (BCD) without stopping.
- R5: Mode 0: `out` is high exactly when d ≥ N, and stays high from then on.
- R6: Mode 1: `out` is high exactly when d < N.
- R7: Mode 2 (periodic): `count` = N − (d mod N). `out` is high for one tick whenever d is a nonzero multiple of N.
- R8: Mode 3 (square wave, N ≥ 2), with p = d mod N and H = (N+1)/2. `out` is high while p < H. `count` is N − 2p in the high half and (N rounded down to even) − 2(p − H) in the low half, so it steps by two.
- R9: Modes 4 and 5: `out` is high for exactly the one tick during which d = N, and never again until the next load or restart.
- R10: In modes 1, 2, 3 and 5, a rising edge on `gate` (relative to the previous cycle) restarts counting with d = 0.
- R11: In modes 0 and 4, `gate` low stops d from advancing. In modes 1, 2, 3 and 5, the gate level does not affect counting.
- R12: With `bcd` = 1, `init_count` is read as four decimal digits (bits 15:12 thousands down to bits 3:0 units), and `count` is shown in the same four-digit encoding.
- R13: Without a tick, load or restart, `out` and `count` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Counting enable, one count per high cycle |
| gate | input | 1 | Gate level (suspend or retrigger depending on mode) |
| load | input | 1 | Strobe: capture configuration and start counting |
| init_count | input | 16 | Initial count, binary or four BCD digits |
| mode | input | 3 | Operating mode 0..7 (6 and 7 alias 2 and 3) |
| bcd | input | 1 | 1 = decimal counting, 0 = binary |
| out | output | 1 | Mode waveform output |
| count | output | 16 | Current counter value in the selected base |

## Verification
Two situations are hard to reach from the ports: the zero-means-maximum count and the wrap below zero. The first needs N ticks before anything visible happens, and the second only occurs after the terminal point has passed. The stimulus reaches the wrap with very small initial counts under a steady tick. It also includes one long directed run of a decimal zero count, ten thousand ticks, so the terminal edge at 10000 is actually observed. Gate edges that coincide with ticks and loads are covered by random gate toggling over many short episodes. Every cycle is compared against a model computed from the elapsed-tick formulas.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;

  typedef enum logic [2:0] {
    TM_TERMINAL    = 3'd0,
    TM_ONESHOT     = 3'd1,
    TM_RATE        = 3'd2,
    TM_SQUARE      = 3'd3,
    TM_SOFT_STROBE = 3'd4,
    TM_HARD_STROBE = 3'd5
  } tmode_e;

  // codes 6 and 7 alias the two periodic modes
  function automatic tmode_e fold_mode(input logic [2:0] raw);
    if (raw[2:1] == 2'b11) return tmode_e'({1'b0, raw[1:0]});
    return tmode_e'(raw);
  endfunction

  function automatic int pow10(input int n);
    int r;
    r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  function automatic logic edge_restarts(input tmode_e m);
    return (m == TM_ONESHOT) || (m == TM_RATE) || (m == TM_SQUARE) || (m == TM_HARD_STROBE);
  endfunction

  function automatic logic level_holds(input tmode_e m);
    return (m == TM_TERMINAL) || (m == TM_SOFT_STROBE);
  endfunction

endpackage

// File: rtl/timer_bcd_to_bin.sv
`timescale 1ns/1ps
module timer_bcd_to_bin #(
  parameter int DIGITS = 4,
  localparam int CW = 4 * DIGITS,
  localparam int VW = CW + 1
) (
  input  logic [CW-1:0] digits_i,
  output logic [VW-1:0] value_o
);
  always_comb begin
    value_o = '0;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      value_o = value_o * VW'(10) + VW'(digits_i[i*4 +: 4]);
    end
  end
endmodule

// File: rtl/timer_bin_to_bcd.sv
`timescale 1ns/1ps
module timer_bin_to_bcd #(
  parameter int DIGITS = 4,
  localparam int CW = 4 * DIGITS,
  localparam int VW = CW + 1
) (
  input  logic [VW-1:0] value_i,
  output logic [CW-1:0] digits_o
);
  logic [VW-1:0] rest;
  always_comb begin
    rest = value_i;
    digits_o = '0;
    for (int i = 0; i < DIGITS; i++) begin
      digits_o[i*4 +: 4] = 4'(rest % VW'(10));
      rest = rest / VW'(10);
    end
  end
endmodule

// File: rtl/timer_count_core.sv
`timescale 1ns/1ps
module timer_count_core
  import timer_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int CW = 4 * DIGITS,
  localparam int VW = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  tmode_e        mode_i,
  input  logic          bcd_i,
  input  logic [VW-1:0] n_i,
  input  logic          restart_i,
  input  logic          adv_i,
  output logic          out_o,
  output logic [VW-1:0] cnt_o,
  output tmode_e        mode_o,
  output logic          bcd_o,
  output logic          armed_o,
  output logic [VW-1:0] n_o
);
  localparam logic [VW-1:0] BIN_TOP = {1'b0, {CW{1'b1}}};
  localparam logic [VW-1:0] DEC_TOP = VW'(pow10(DIGITS) - 1);

  tmode_e        mode_q;
  logic          bcd_q, armed_q, wrapped_q, pulse_q, half_q;
  logic [VW-1:0] n_q, c_q;
  logic          reached;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      mode_q    <= TM_TERMINAL;
      bcd_q     <= 1'b0;
      n_q       <= '0;
      c_q       <= '0;
      wrapped_q <= 1'b0;
      pulse_q   <= 1'b0;
      half_q    <= 1'b1;
    end else if (load_i) begin
      armed_q   <= 1'b1;
      mode_q    <= mode_i;
      bcd_q     <= bcd_i;
      n_q       <= n_i;
      c_q       <= n_i;
      wrapped_q <= 1'b0;
      pulse_q   <= 1'b0;
      half_q    <= 1'b1;
    end else if (restart_i) begin
      c_q       <= n_q;
      wrapped_q <= 1'b0;
      pulse_q   <= 1'b0;
      half_q    <= 1'b1;
    end else if (adv_i) begin
      case (mode_q)
        TM_RATE: begin
          if (c_q == VW'(1)) begin
            c_q     <= n_q;
            pulse_q <= 1'b1;
          end else begin
            c_q     <= c_q - VW'(1);
            pulse_q <= 1'b0;
          end
        end
        TM_SQUARE: begin
          if (c_q <= VW'(2)) begin
            half_q <= ~half_q;
            c_q    <= half_q ? {n_q[VW-1:1], 1'b0} : n_q;
          end else begin
            c_q <= c_q - VW'(2);
          end
        end
        default: begin
          if (c_q == '0) begin
            c_q       <= bcd_q ? DEC_TOP : BIN_TOP;
            wrapped_q <= 1'b1;
          end else begin
            c_q <= c_q - VW'(1);
          end
        end
      endcase
    end
  end

  assign reached = (c_q == '0) || wrapped_q;

  always_comb begin
    case (mode_q)
      TM_TERMINAL: out_o = reached;
      TM_ONESHOT:  out_o = !reached;
      TM_RATE:     out_o = pulse_q;
      TM_SQUARE:   out_o = half_q;
      default:     out_o = (c_q == '0) && !wrapped_q;
    endcase
    if (!armed_q) out_o = 1'b0;
  end

  assign cnt_o   = c_q;
  assign mode_o  = mode_q;
  assign bcd_o   = bcd_q;
  assign armed_o = armed_q;
  assign n_o     = n_q;
endmodule

// File: rtl/timer_channel.sv
`timescale 1ns/1ps
module timer_channel
  import timer_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int CW = 4 * DIGITS,
  localparam int VW = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          gate,
  input  logic          load,
  input  logic [CW-1:0] init_count,
  input  logic [2:0]    mode,
  input  logic          bcd,
  output logic          out,
  output logic [CW-1:0] count
);
  localparam logic [VW-1:0] BIN_MOD = {1'b1, {CW{1'b0}}};
  localparam logic [VW-1:0] DEC_MOD = VW'(pow10(DIGITS));

  logic          gate_q, restart, adv, bcd_q, armed;
  tmode_e        mode_q;
  logic [VW-1:0] init_dec, n_raw, n_load, n_q, c_val, disp;
  logic [CW-1:0] disp_bcd;

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate;
  end

  assign restart = armed && gate && !gate_q && edge_restarts(mode_q);
  assign adv     = armed && tick && (gate || !level_holds(mode_q));

  timer_bcd_to_bin #(.DIGITS(DIGITS)) u_dec (
    .digits_i(init_count),
    .value_o (init_dec)
  );

  assign n_raw  = bcd ? init_dec : {1'b0, init_count};
  assign n_load = (n_raw == '0) ? (bcd ? DEC_MOD : BIN_MOD) : n_raw;

  timer_count_core #(.DIGITS(DIGITS)) u_core (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .mode_i   (fold_mode(mode)),
    .bcd_i    (bcd),
    .n_i      (n_load),
    .restart_i(restart),
    .adv_i    (adv),
    .out_o    (out),
    .cnt_o    (c_val),
    .mode_o   (mode_q),
    .bcd_o    (bcd_q),
    .armed_o  (armed),
    .n_o      (n_q)
  );

  assign disp = (c_val == (bcd_q ? DEC_MOD : BIN_MOD)) ? '0 : c_val;

  timer_bin_to_bcd #(.DIGITS(DIGITS)) u_enc (
    .value_i (disp),
    .digits_o(disp_bcd)
  );

  assign count = bcd_q ? disp_bcd : disp[CW-1:0];
endmodule

// File: rtl/timer_channel_chk.sv
`timescale 1ns/1ps
module timer_channel_chk #(
  parameter int DIGITS = 4,
  localparam int CW = 4 * DIGITS,
  localparam int VW = CW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          gate,
  input logic          load,
  input logic [2:0]    mode,
  input logic          out,
  input logic [CW-1:0] count,
  input logic [2:0]    mode_q,
  input logic          bcd_q,
  input logic          armed,
  input logic [VW-1:0] n_q,
  input logic          restart,
  input logic          adv
);
  logic digits_ok;
  always_comb begin
    digits_ok = 1'b1;
    for (int i = 0; i < DIGITS; i++)
      if (count[i*4 +: 4] > 4'd9) digits_ok = 1'b0;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out && count == '0));

  // R2
  mode_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (load && mode[2:1] == 2'b11) |=> (mode_q == {1'b0, $past(mode[1:0])}));

  // R5
  latch_high_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && mode_q == 3'd0 && out && !load) |=> out);

  // R7
  rate_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && mode_q == 3'd2 && n_q > VW'(1) && out && adv && !load && !restart) |=> !out);

  // R9
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && (mode_q == 3'd4 || mode_q == 3'd5) && out && adv && !load && !restart) |=> !out);

  // R11
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && (mode_q == 3'd0 || mode_q == 3'd4) && !gate && !load) |=> $stable(count));

  // R12
  bcd_digits_chk: assert property (@(posedge clk) disable iff (rst)
    bcd_q |-> digits_ok);

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load && !restart) |=> ($stable(out) && $stable(count)));
endmodule

bind timer_channel timer_channel_chk #(.DIGITS(DIGITS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .tick   (tick),
  .gate   (gate),
  .load   (load),
  .mode   (mode),
  .out    (out),
  .count  (count),
  .mode_q (mode_q),
  .bcd_q  (bcd_q),
  .armed  (armed),
  .n_q    (n_q),
  .restart(restart),
  .adv    (adv)
);

// File: tb/test_timer_channel.sv
`timescale 1ns/1ps
module test_timer_channel;
  logic        clk = 1'b0;
  logic        rst, tick, gate, load, bcd, out;
  logic [15:0] init_count, count;
  logic [2:0]  mode;

  always #10 clk = ~clk;

  timer_channel i_timer_channel (
    .clk(clk), .rst(rst), .tick(tick), .gate(gate), .load(load),
    .init_count(init_count), .mode(mode), .bcd(bcd),
    .out(out), .count(count)
  );

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;

  // reference state
  bit  armed_m;
  int  n_m;
  int  mode_m;
  bit  bcd_m;
  int  d_m;
  bit  gate_prev;

  function automatic int from_bcd(input logic [15:0] v);
    int r;
    r = 0;
    for (int i = 3; i >= 0; i--) r = r * 10 + int'(v[i*4 +: 4]);
    return r;
  endfunction

  function automatic logic [15:0] to_bcd(input int v);
    logic [15:0] r;
    int t;
    t = v;
    for (int i = 0; i < 4; i++) begin
      r[i*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic int base_of(input bit b);
    return b ? 10000 : 65536;
  endfunction

  function automatic bit exp_out();
    int p, h;
    if (!armed_m) return 1'b0;
    p = d_m % n_m;
    h = (n_m + 1) / 2;
    case (mode_m)
      0: return d_m >= n_m;
      1: return d_m < n_m;
      2: return (d_m != 0) && (p == 0);
      3: return p < h;
      default: return d_m == n_m;
    endcase
  endfunction

  function automatic logic [15:0] exp_count();
    int v, p, h, m;
    if (!armed_m) return 16'h0000;
    m = base_of(bcd_m);
    p = d_m % n_m;
    h = (n_m + 1) / 2;
    case (mode_m)
      2: v = n_m - p;
      3: v = (p < h) ? (n_m - 2 * p) : ((n_m & ~1) - 2 * (p - h));
      default: begin
        v = (n_m - (d_m % m)) % m;
        if (v < 0) v = v + m;
      end
    endcase
    if (v == m) v = 0;
    return bcd_m ? to_bcd(v) : 16'(v);
  endfunction

  task automatic check(input string tag);
    logic        eo;
    logic [15:0] ec;
    eo = exp_out();
    ec = exp_count();
    n_checks++;
    if (out !== eo) begin
      n_fail++;
      $display("FAIL %s out actual=%0b expected=%0b at %0t", tag, out, eo, $time);
    end
    n_checks++;
    if (count !== ec) begin
      n_fail++;
      $display("FAIL %s count actual=%h expected=%h at %0t", tag, count, ec, $time);
    end
  endtask

  task automatic step(input bit ld, input logic [15:0] ic, input logic [2:0] md,
                      input bit b, input bit tk, input bit gt, input string tag);
    int eff;
    bit rise;
    load = ld; init_count = ic; mode = md; bcd = b; tick = tk; gate = gt;
    @(posedge clk);
    #2;
    eff = (md >= 3'd6) ? int'(md) - 4 : int'(md);
    rise = gt && !gate_prev;
    if (ld) begin
      armed_m = 1'b1;
      n_m = b ? from_bcd(ic) : int'(ic);
      if (n_m == 0) n_m = base_of(b);
      mode_m = eff;
      bcd_m = b;
      d_m = 0;
    end else if (armed_m) begin
      if (rise && (mode_m == 1 || mode_m == 2 || mode_m == 3 || mode_m == 5))
        d_m = 0;
      else if (tk && (gt || !(mode_m == 0 || mode_m == 4)))
        d_m = d_m + 1;
    end
    gate_prev = gt;
    load = 1'b0;
    check(tag);
  endtask

  task automatic run(input int n, input bit tk, input bit gt, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, init_count, mode, bcd, tk, gt, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; load = 1'b0; tick = 1'b1; gate = 1'b1;
    init_count = 16'h0000; mode = 3'd0; bcd = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    armed_m = 1'b0; gate_prev = 1'b0; d_m = 0; n_m = 1; mode_m = 0; bcd_m = 0;
    check("R1 reset state");
  endtask

  function automatic string tag_of(input int m);
    case (m)
      0: return "R5 random mode0";
      1: return "R6 random mode1";
      2: return "R7 random mode2";
      3: return "R8 random mode3";
      default: return "R9 random strobe";
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    do_reset();
    // R1: ticks and gate edges before any load change nothing
    for (int i = 0; i < 6; i++) step(1'b0, 16'h0007, 3'd2, 1'b0, 1'b1, bit'(i % 2), "R1 idle");

    // R5 / R4: mode 0 binary, small count, runs through the wrap
    step(1'b1, 16'd3, 3'd0, 1'b0, 1'b0, 1'b1, "R2 load mode0");
    run(8, 1'b1, 1'b1, "R4 binary wrap");
    // R6
    step(1'b1, 16'd4, 3'd1, 1'b0, 1'b1, 1'b1, "R6 load mode1");
    run(7, 1'b1, 1'b1, "R6 oneshot");
    // R7
    step(1'b1, 16'd3, 3'd2, 1'b0, 1'b1, 1'b1, "R7 load mode2");
    run(10, 1'b1, 1'b1, "R7 rate");
    // R8 odd and even
    step(1'b1, 16'd5, 3'd3, 1'b0, 1'b1, 1'b1, "R8 load odd");
    run(12, 1'b1, 1'b1, "R8 square odd");
    step(1'b1, 16'd6, 3'd3, 1'b0, 1'b1, 1'b1, "R8 load even");
    run(13, 1'b1, 1'b1, "R8 square even");
    // R9 both strobe modes
    step(1'b1, 16'd4, 3'd4, 1'b0, 1'b1, 1'b1, "R9 load mode4");
    run(8, 1'b1, 1'b1, "R9 soft strobe");
    step(1'b1, 16'd2, 3'd5, 1'b0, 1'b1, 1'b1, "R9 load mode5");
    run(6, 1'b1, 1'b1, "R9 hard strobe");
    // R12 / R4: decimal wrap to 9999
    step(1'b1, 16'h0003, 3'd4, 1'b1, 1'b1, 1'b1, "R12 load bcd");
    run(7, 1'b1, 1'b1, "R12 bcd wrap");
    step(1'b1, 16'h0105, 3'd2, 1'b1, 1'b1, 1'b1, "R12 load bcd 105");
    run(110, 1'b1, 1'b1, "R12 bcd rate");
    // R3 binary zero count
    step(1'b1, 16'h0000, 3'd2, 1'b0, 1'b1, 1'b1, "R3 load zero bin");
    run(4, 1'b1, 1'b1, "R3 zero bin");
    // R3 decimal zero count, full period
    step(1'b1, 16'h0000, 3'd0, 1'b1, 1'b0, 1'b1, "R3 load zero bcd");
    run(10003, 1'b1, 1'b1, "R3 zero bcd");
    // R2 aliases
    step(1'b1, 16'd4, 3'd6, 1'b0, 1'b1, 1'b1, "R2 alias 6");
    run(10, 1'b1, 1'b1, "R2 alias 6 run");
    step(1'b1, 16'd5, 3'd7, 1'b0, 1'b1, 1'b1, "R2 alias 7");
    run(12, 1'b1, 1'b1, "R2 alias 7 run");
    // R2 load beats a tick and a gate rise in the same cycle
    step(1'b0, 16'd5, 3'd7, 1'b0, 1'b1, 1'b0, "R2 pre");
    step(1'b1, 16'd9, 3'd1, 1'b0, 1'b1, 1'b1, "R2 load priority");
    run(3, 1'b1, 1'b1, "R2 after load");
    // R10 restart in modes 1 and 3
    run(2, 1'b1, 1'b0, "R10 gate low mode1");
    step(1'b0, init_count, mode, bcd, 1'b1, 1'b1, "R10 rise mode1");
    run(11, 1'b1, 1'b1, "R10 after rise");
    step(1'b1, 16'd7, 3'd3, 1'b0, 1'b1, 1'b1, "R10 load mode3");
    run(3, 1'b1, 1'b1, "R10 mode3 run");
    step(1'b0, init_count, mode, bcd, 1'b1, 1'b0, "R10 mode3 low");
    step(1'b0, init_count, mode, bcd, 1'b1, 1'b1, "R10 mode3 rise");
    run(4, 1'b1, 1'b1, "R10 mode3 after");
    // R11 gate low holds mode 4, not mode 2
    step(1'b1, 16'd6, 3'd4, 1'b0, 1'b1, 1'b1, "R11 load mode4");
    run(2, 1'b1, 1'b1, "R11 mode4 run");
    run(5, 1'b1, 1'b0, "R11 mode4 held");
    run(6, 1'b1, 1'b1, "R11 mode4 resume");
    step(1'b1, 16'd4, 3'd2, 1'b0, 1'b1, 1'b0, "R11 load mode2");
    run(6, 1'b1, 1'b0, "R11 mode2 ungated");
    // R13 no ticks
    step(1'b1, 16'd5, 3'd3, 1'b0, 1'b1, 1'b1, "R13 load");
    run(2, 1'b1, 1'b1, "R13 run");
    run(6, 1'b0, 1'b1, "R13 no tick");

    // random episodes
    for (int e = 0; e < 80; e++) begin
      int md, nv, len;
      bit b, g;
      logic [15:0] ic;
      md = $urandom_range(0, 7);
      b  = bit'($urandom_range(0, 1));
      nv = (md == 2 || md == 3 || md >= 6) ? $urandom_range(2, 40) : $urandom_range(1, 40);
      ic = b ? to_bcd(nv) : 16'(nv);
      g  = 1'b1;
      len = $urandom_range(30, 120);
      step(1'b1, ic, 3'(md), b, 1'b1, g, "R2 random load");
      for (int k = 0; k < len; k++) begin
        bit tk, ld;
        tk = ($urandom_range(0, 9) < 7);
        if ($urandom_range(0, 7) == 0) g = ~g;
        ld = ($urandom_range(0, 99) == 0);
        step(ld, ic, 3'(md), b, tk, g, tag_of(mode_m));
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule